// File: doc/BRIEF.md
# Parallel-Bus Converter Interface Controller

This block is the digital control side of a 12-bit converter that hangs on a parallel, three-state data bus. A falling edge on the active-low start input begins a conversion of fixed length, measured in clock cycles. For the whole of that conversion the active-low busy output is held low. The analog front end is replaced by a `sample` port, which is captured at the start edge. The conversion result is the captured sample plus a signed offset word, clamped to the 12-bit unsigned range.

Two latching modes are selectable. In end-latch mode (`defer_latch` = 0), the output register takes the new result on the same clock edge that busy is released. In deferred mode (`defer_latch` = 1), busy is released when the conversion ends, but the finished result moves into the output register only when the next accepted start edge arrives. Until then, a read returns the result before it.

The host reads the output register by pulling chip-select and read low. It loads the offset by placing a word on the same bus and pulsing the write input high while chip-select is low. Chip-select may be tied low permanently. While standby or nap is high, start edges are refused. All inputs are assumed to be synchronous to `clk`.

Top module: `pbus_adc_if`

## Requirements
- R1: After a synchronous reset, `busy_n` is 1, the output register reads 0 and the offset register holds 0.
- R2: At the first rising clock edge where `conv_n` is sampled low after being sampled high, with the block idle and neither standby nor nap high, `busy_n` goes low. It stays low for exactly CONV_CYCLES clock cycles and then returns high.
- R3: A falling edge on `conv_n` while `busy_n` is low has no effect. The running conversion is neither extended nor restarted, and no second conversion follows it.
- R4: A falling edge on `conv_n` while `standby` or `nap` is high starts no conversion. `busy_n` stays high and the output register is unchanged.
- R5: With `defer_latch` = 0, the output register holds the new result on the same edge that `busy_n` returns high.
- R6: With `defer_latch` = 1, `busy_n` returns high when the conversion ends but the output register is unchanged. On the next accepted start edge, the output register takes the previous conversion's result. The output register only changes on such an edge or, in end-latch mode, at conversion end.
- R7: The result is `sample` as captured at the start edge, plus the offset register read as 12-bit two's complement, saturated to 0..4095.
- R8: `dbus` carries the output register, with bit 11 as the most significant bit, only while `cs_n` = 0, `rd_n` = 0 and `wr` = 0. In every other case it is high impedance, and the change takes effect within the same cycle.
- R9: With `cs_n` low, the falling edge of `wr` loads the offset register with the bus word present in the last cycle that `wr` was high. A `wr` pulse while `cs_n` is high leaves the offset unchanged.
- R10: With `cs_n` held low throughout, reads controlled by `rd_n` alone and offset writes controlled by `wr` alone work as in R8 and R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_n | input | 1 | Conversion start; falling edge starts |
| defer_latch | input | 1 | 0: latch at conversion end, 1: latch at next start |
| standby | input | 1 | Low-power request, refuses starts |
| nap | input | 1 | Deeper low-power request, refuses starts |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| wr | input | 1 | Offset write pulse, captured on its falling edge |
| sample | input | 12 | Stand-in for the analog input value |
| busy_n | output | 1 | Low while a conversion runs |
| dbus | inout | 12 | Three-state data bus |

## Verification
A wrong conversion counter shows on `busy_n` within one conversion, as a low pulse that is longer or shorter than CONV_CYCLES. A refused start that slips through is visible at the very next edge. A fault in the result path or the mode decision only appears when the register is read. For that reason, the bench reads in the same cycle that busy rises, and again after the following start edge, so that a one-edge error in where the latch happens is caught. A bus enable that leaks drives the bus against the bench in the same cycle, and the bench reads that conflict back.

// File: rtl/adc_if_pkg.sv
// Shared types for the parallel-bus converter interface.
package adc_if_pkg;

    // Selects the point at which a finished result reaches the output register.
    typedef enum logic {
        LATCH_AT_END   = 1'b0,
        LATCH_AT_START = 1'b1
    } latch_mode_e;

endpackage

// File: rtl/adc_conv_timer.sv
// Conversion timer: an accepted start loads a down-counter, and the timer
// then stays busy for exactly CONV_CYCLES clock cycles.
// Assumes: the start input is a one-cycle pulse, and it is raised only while
// the timer is idle (the top module gates it).
module adc_conv_timer #(
    parameter int CONV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] remain;

    // Conversion ends in the cycle where the counter has run out.
    assign done = busy && (remain == '0);

    // Load on start, count down while busy, drop busy at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= LOAD;
        end else if (done) begin
            busy   <= 1'b0;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/adc_offset_sat.sv
// Adds a signed offset to an unsigned sample and clamps the sum to the
// unsigned range of the sample width. Purely combinational.
// Assumes: the offset is two's complement with the same width as the sample.
module adc_offset_sat #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] offset,
    output logic [DW-1:0] result
);
    localparam int SW = DW + 2;

    logic [SW-1:0] sum;

    // Widen both operands and add; the top bit of sum then flags a negative result.
    assign sum = {2'b00, raw} + {{2{offset[DW-1]}}, offset};

    // Clamp: negative goes to zero, anything above full scale goes to all ones.
    always_comb begin
        if (sum[SW-1])
            result = '0;
        else if (sum[DW])
            result = '1;
        else
            result = sum[DW-1:0];
    end
endmodule

// File: rtl/adc_result_regs.sv
// Holds the sample captured at the start edge, the most recent finished
// result, and the output register that the bus reads.
// Assumes: start and done are never high in the same cycle.
module adc_result_regs
    import adc_if_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        done,
    input  latch_mode_e mode,
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] held,
    output logic [DW-1:0] out_word
);
    logic [DW-1:0] pending;

    // Track-and-hold: freeze the sample when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (start)
            held <= sample;
    end

    // Keep every finished result so that deferred mode can publish it later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else if (done)
            pending <= result;
    end

    // Update the output register at conversion end or at the next start, depending on mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_word <= '0;
        else if (done && mode == LATCH_AT_END)
            out_word <= result;
        else if (start && mode == LATCH_AT_START)
            out_word <= pending;
    end
endmodule

// File: rtl/adc_bus_port.sv
// Bus side: decides when the output register is driven and captures
// offset writes on the falling edge of the write pulse.
// Assumes: the host holds the write data on the bus while wr is high.
module adc_bus_port #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr,
    input  logic [DW-1:0] bus_in,
    output logic          drive_en,
    output logic [DW-1:0] offset
);
    logic          wr_q;
    logic [DW-1:0] bus_q;
    logic          wr_fall;

    // Drive only for a selected read, never while a write is in progress.
    assign drive_en = !cs_n && !rd_n && !wr;
    assign wr_fall  = wr_q && !wr;

    // Delay wr and the bus by one cycle to find the write strobe's falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            bus_q <= '0;
        end else begin
            wr_q  <= wr;
            bus_q <= bus_in;
        end
    end

    // Take the word that was on the bus while wr was still high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offset <= '0;
        else if (wr_fall && !cs_n)
            offset <= bus_q;
    end
endmodule

// File: rtl/pbus_adc_if.sv
// Top of the parallel-bus converter interface: start-edge detection and
// low-power gating, the conversion timer, the result path and the
// three-state bus.
// Assumes: all inputs are synchronous to clk; sample is the converter's
// analog value already in digital form.
module pbus_adc_if
    import adc_if_pkg::*;
#(
    parameter int DW          = 12,
    parameter int CONV_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_n,
    input  logic          defer_latch,
    input  logic          standby,
    input  logic          nap,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr,
    input  logic [DW-1:0] sample,
    output logic          busy_n,
    inout  wire  [DW-1:0] dbus
);
    logic          conv_q;
    logic          conv_fall;
    logic          low_power;
    logic          start_ok;
    logic          busy;
    logic          done;
    logic          drive_en;
    logic [DW-1:0] held;
    logic [DW-1:0] result;
    logic [DW-1:0] out_word;
    logic [DW-1:0] offset;
    latch_mode_e   mode;

    assign mode      = defer_latch ? LATCH_AT_START : LATCH_AT_END;
    assign low_power = standby || nap;
    assign conv_fall = conv_q && !conv_n;
    assign start_ok  = conv_fall && !busy && !low_power;
    assign busy_n    = !busy;
    assign dbus      = drive_en ? out_word : {DW{1'bz}};

    // Remember the previous level of the start input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            conv_q <= 1'b1;
        else
            conv_q <= conv_n;
    end

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_ok),
        .busy  (busy),
        .done  (done)
    );

    adc_offset_sat #(.DW(DW)) u_sat (
        .raw    (held),
        .offset (offset),
        .result (result)
    );

    adc_result_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_ok),
        .done     (done),
        .mode     (mode),
        .sample   (sample),
        .result   (result),
        .held     (held),
        .out_word (out_word)
    );

    adc_bus_port #(.DW(DW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr       (wr),
        .bus_in   (dbus),
        .drive_en (drive_en),
        .offset   (offset)
    );
endmodule

// File: rtl/pbus_adc_if_checks.sv
// Property checker for pbus_adc_if, attached to it with bind.
// Assumes: a synchronous active-low reset; it measures busy pulse length with its own counter.
module pbus_adc_if_checks #(
    parameter int DW          = 12,
    parameter int CONV_CYCLES = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_n,
    input logic          standby,
    input logic          nap,
    input logic          busy_n,
    input logic [DW-1:0] out_word
);
    localparam int RW = $clog2(CONV_CYCLES + 2);

    logic [RW-1:0] low_run;

    // Count the cycles busy_n has been low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (busy_n)
            low_run <= '0;
        else
            low_run <= low_run + 1'b1;
    end

    // R2: an allowed start edge while idle pulls busy low at the next edge.
    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !standby && !nap && !conv_n && $past(conv_n)) |=> !busy_n);

    // R3: every busy pulse is exactly CONV_CYCLES long, whatever happens on conv_n.
    assert_pulse_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_run == RW'(CONV_CYCLES)));

    // R4: while a low-power input is high, an idle block stays idle.
    assert_lowpower_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && (standby || nap)) |=> busy_n);

    // R6: across an idle stretch the output register does not move.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && $past(busy_n)) |-> $stable(out_word));
endmodule

bind pbus_adc_if pbus_adc_if_checks #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_n   (conv_n),
    .standby  (standby),
    .nap      (nap),
    .busy_n   (busy_n),
    .out_word (out_word)
);

// File: tb/pbus_adc_if_test.sv
// Self-checking bench for pbus_adc_if: a vector table walked by one loop,
// then directed tests for reset, ordering and bus corner cases.
module pbus_adc_if_test;
    localparam int DW = 12;
    localparam int C  = 8;

    // Each entry: sample[35:24], offset[23:12], expected result[11:0].
    localparam logic [35:0] VECS [0:7] = '{
        {12'd100,  12'h000, 12'd100},
        {12'd100,  12'h032, 12'd150},
        {12'd100,  12'hF38, 12'd0},
        {12'd4000, 12'h0C8, 12'd4095},
        {12'd2048, 12'hFFF, 12'd2047},
        {12'hABC,  12'h000, 12'hABC},
        {12'd4095, 12'h7FF, 12'd4095},
        {12'd0,    12'h800, 12'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_n = 1'b1;
    logic defer_latch = 1'b0;
    logic standby = 1'b0;
    logic nap = 1'b0;
    logic cs_n = 1'b1;
    logic rd_n = 1'b1;
    logic wr = 1'b0;
    logic [DW-1:0] sample = '0;
    logic busy_n;
    wire  [DW-1:0] dbus;
    logic          tb_en = 1'b0;
    logic [DW-1:0] tb_drv = '0;
    logic          cs_tie = 1'b0;
    int compared = 0;
    int mismatched = 0;

    assign dbus = tb_en ? tb_drv : {DW{1'bz}};

    always #2 clk = ~clk;

    pbus_adc_if #(.DW(DW), .CONV_CYCLES(C)) uut (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .defer_latch(defer_latch),
        .standby(standby), .nap(nap), .cs_n(cs_n), .rd_n(rd_n), .wr(wr),
        .sample(sample), .busy_n(busy_n), .dbus(dbus)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read the output register within the current cycle.
    task automatic read_now(output logic [DW-1:0] val);
        cs_n = 1'b0;
        rd_n = 1'b0;
        #1;
        val = dbus;
        rd_n = 1'b1;
        cs_n = cs_tie ? 1'b0 : 1'b1;
    endtask

    task automatic write_off(input logic [DW-1:0] val, input logic sel);
        @(negedge clk);
        cs_n = !sel;
        wr = 1'b1;
        tb_drv = val;
        tb_en = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        tb_en = 1'b0;
        cs_n = cs_tie ? 1'b0 : 1'b1;
    endtask

    // Leaves the caller one negedge after the start edge was sampled (N1).
    task automatic start(input logic [DW-1:0] s);
        @(negedge clk);
        sample = s;
        conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1;
    endtask

    // From N1: busy still low at N_C, released at N_C+1.
    task automatic wait_end(input string req);
        repeat (C - 1) @(negedge clk);
        #1 check(req, {11'd0, busy_n}, 12'd0);
        @(negedge clk);
        #1 check(req, {11'd0, busy_n}, 12'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic held_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, output register and offset both zero
        #1 check("R1 busy_n", {11'd0, busy_n}, 12'd1);
        read_now(v);
        check("R1 out", v, 12'd0);
        start(12'd55);
        wait_end("R1 timing");
        read_now(v);
        check("R1 offset zero", v, 12'd55);

        // R2/R5/R7/R9: table walk, end-latch mode
        for (int i = 0; i < 8; i++) begin
            write_off(VECS[i][23:12], 1'b1);
            start(VECS[i][35:24]);
            #1 check("R2 busy low", {11'd0, busy_n}, 12'd0);
            wait_end("R2 length");
            read_now(v);
            check("R5 R7 R9 result", v, VECS[i][11:0]);
        end

        // R3: a start edge during a conversion neither extends nor repeats it
        write_off(12'h000, 1'b1);
        start(12'h321);
        @(negedge clk);
        conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1;
        repeat (C - 3) @(negedge clk);
        #1 check("R3 still busy", {11'd0, busy_n}, 12'd0);
        @(negedge clk);
        #1 check("R3 released", {11'd0, busy_n}, 12'd1);
        @(negedge clk);
        #1 check("R3 no rerun", {11'd0, busy_n}, 12'd1);
        read_now(v);
        check("R3 value", v, 12'h321);

        // R4: standby, then nap, each refuse a start
        for (int k = 0; k < 2; k++) begin
            standby = (k == 0);
            nap = (k == 1);
            start(12'h0AA);
            held_hi = 1'b1;
            repeat (C + 1) begin
                #1 if (!busy_n) held_hi = 1'b0;
                @(negedge clk);
            end
            check("R4 busy held high", {11'd0, held_hi}, 12'd1);
            standby = 1'b0;
            nap = 1'b0;
            read_now(v);
            check("R4 out unchanged", v, 12'h321);
        end

        // R8: bench drives 0 where the block must float; a leak shows as non-zero
        @(negedge clk);
        tb_drv = 12'h000;
        tb_en = 1'b1;
        cs_n = 1'b1; rd_n = 1'b0;
        #1 check("R8 float cs high", dbus, 12'h000);
        cs_n = 1'b0; rd_n = 1'b1;
        #1 check("R8 float rd high", dbus, 12'h000);
        cs_n = 1'b0; rd_n = 1'b0; wr = 1'b1;
        #1 check("R8 float during write", dbus, 12'h000);
        rd_n = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        tb_en = 1'b0;
        cs_n = 1'b1;
        read_now(v);
        check("R8 msb and value", v, 12'h321);
        check("R8 bit 11", {11'd0, v[11]}, 12'd0);

        // R6: deferred latching
        defer_latch = 1'b1;
        start(12'h123);
        wait_end("R6 busy");
        read_now(v);
        check("R6 held old", v, 12'h321);
        start(12'h456);
        #1 read_now(v);
        check("R6 latched at next start", v, 12'h123);
        wait_end("R6 busy 2");
        read_now(v);
        check("R6 end keeps", v, 12'h123);
        defer_latch = 1'b0;

        // R9: a write with chip-select high is ignored
        write_off(12'h100, 1'b0);
        start(12'd7);
        wait_end("R9 busy");
        read_now(v);
        check("R9 deselected write", v, 12'd7);

        // R10: chip-select tied low for writes and reads
        cs_tie = 1'b1;
        cs_n = 1'b0;
        write_off(12'd5, 1'b1);
        start(12'd7);
        wait_end("R10 busy");
        read_now(v);
        check("R10 tied cs", v, 12'd12);
        @(negedge clk);
        tb_drv = 12'h000;
        tb_en = 1'b1;
        #1 check("R10 float rd high", dbus, 12'h000);
        tb_en = 1'b0;
        cs_tie = 1'b0;
        cs_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule